// File: doc/BRIEF.md
# DMA Command Queue with Tag-Group Ordering

This block sits between a local processor and a memory request port in a DMA engine. The processor hands it transfer commands. A GET moves data from memory into local storage and a PUT moves it the other way. The queue holds each command in one of a fixed set of slots and issues memory requests for it. When the memory side reports a request finished, the queue retires the command. Each command is either one transfer or a list of transfer elements that gather or scatter data. Each command carries a 5-bit tag that places it in a tag group. It may also carry a fence flag, a barrier flag, or both.

A list command gives an element count and a list pointer. For each element, the queue puts the element's pointer on a combinational read port, receives that element's address and size on the same port, and issues them as one request. The elements of one list are always issued in list order. This order lets software place a list at the tail of the buffer the list fills. Commands with no ordering flags may pass each other. A fence holds a command back only behind earlier commands in its own tag group. A barrier holds a command back behind all earlier commands. A mask shows which tag groups currently have nothing outstanding.

Top module: `dma_cmd_queue`

## Requirements
- R1: The queue holds up to SLOTS (16) commands. `cmd_ready` is low exactly when all slots are occupied. A command offered while `cmd_ready` is low is not accepted and never produces a request.
- R2: A single-transfer command (`cmd_list`=0) produces exactly one request. The request carries the command's direction (`mreq_put`: 0 = GET, 1 = PUT), tag, address (`cmd_addr`) and size (`cmd_size`).
- R3: For a list command (`cmd_list`=1), `cmd_size` is the element count and `cmd_addr` is the list pointer. Element k is read with `lst_ptr` = `cmd_addr` + k. Its `lst_addr` and `lst_size` become the request's address and size, and the elements are requested strictly in increasing k.
- R4: A list element whose `lst_size` is 0 raises `list_err` for one cycle and is not requested. The rest of that list is dropped, and the command retires once the elements it already issued have completed.
- R5: A command with `cmd_fence`=1 is not requested until every earlier command with the same tag has completed. Earlier commands with other tags do not hold it back.
- R6: A command with `cmd_barrier`=1 is not requested until every earlier command, whatever its tag, has completed.
- R7: A command without flags is requested as soon as it is queued, even if an earlier command is held by a fence or barrier. Among requestable slots, the lowest slot index goes first.
- R8: A completion names its slot on `mcpl_id`. A command keeps its slot, and its tag stays busy, until all of its issued elements have completed.
- R9: `tag_idle[t]` is 1 exactly when no accepted command with tag t is still held. After reset it is all ones, and in the cycle after a command is accepted its tag reads busy.
- R10: A list command with an element count of 0 makes no request and retires on its own one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | A free slot exists; command accepted when both are high |
| cmd_put | input | 1 | Direction: 0 = GET, 1 = PUT |
| cmd_list | input | 1 | 1 = list command |
| cmd_fence | input | 1 | Fence flag (same tag group) |
| cmd_barrier | input | 1 | Barrier flag (all earlier commands) |
| cmd_tag | input | TAG_W | Tag group |
| cmd_addr | input | ADDR_W | Transfer address, or list pointer for a list |
| cmd_size | input | SIZE_W | Transfer size, or element count for a list |
| lst_rd_en | output | 1 | List element read active |
| lst_ptr | output | ADDR_W | Pointer of the element being read |
| lst_addr | input | ADDR_W | Element address returned for `lst_ptr` |
| lst_size | input | SIZE_W | Element size returned for `lst_ptr` |
| mreq_valid | output | 1 | Memory request offered |
| mreq_ready | input | 1 | Memory side takes the request |
| mreq_put | output | 1 | Request direction |
| mreq_tag | output | TAG_W | Request tag |
| mreq_addr | output | ADDR_W | Request address |
| mreq_size | output | SIZE_W | Request size |
| mreq_id | output | SLOT_W | Slot that issued the request |
| mcpl_valid | input | 1 | A request has completed |
| mcpl_id | input | SLOT_W | Slot of the completed request |
| tag_idle | output | 2**TAG_W | Per-tag idle mask |
| list_err | output | 1 | Zero-size list element seen |

## Verification
The bench holds completions back so that ordering decisions become visible as requests. A fenced command behind a same-tag command must wait, while a later unflagged command in another group overtakes it. A design that checked all tags for a fence, or ignored the flag, would issue in the wrong order. A barrier gets the same treatment across groups. The bench fills all sixteen slots while the memory side stalls and keeps offering a seventeenth command. A queue that accepted it would produce a request with no matching expectation. Lists are fed through a small element memory. The tests cover a list with a zero-size element in the middle, where a design that skipped the element instead of aborting would issue the third element. They also cover an empty list, and a two-element list released one completion at a time, which catches a slot freed after its first completion.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int DCQ_SLOTS  = 16;
  localparam int DCQ_TAG_W  = 5;
  localparam int DCQ_ADDR_W = 32;
  localparam int DCQ_SIZE_W = 12;

  typedef enum logic {
    DIR_GET = 1'b0,
    DIR_PUT = 1'b1
  } dcq_dir_e;
endpackage

// File: rtl/dcq_first_set.sv
module dcq_first_set #(
  parameter int N = 16,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] onehot,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        onehot = '0;
        onehot[i] = 1'b1;
        idx = W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcq_age_matrix.sv
module dcq_age_matrix #(
  parameter int N = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        occupied,
  input  logic [N-1:0]        alloc_oh,
  input  logic [N-1:0]        free_oh,
  output logic [N-1:0][N-1:0] older
);
  logic [N-1:0][N-1:0] older_n;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (alloc_oh[i]) older_n[i] = occupied & ~free_oh;
      else             older_n[i] = older[i] & ~free_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older <= '0;
    else        older <= older_n;
  end
endmodule

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue
  import dcq_pkg::*;
#(
  parameter int SLOTS  = DCQ_SLOTS,
  parameter int TAG_W  = DCQ_TAG_W,
  parameter int ADDR_W = DCQ_ADDR_W,
  parameter int SIZE_W = DCQ_SIZE_W,
  parameter int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_put,
  input  logic                cmd_list,
  input  logic                cmd_fence,
  input  logic                cmd_barrier,
  input  logic [TAG_W-1:0]    cmd_tag,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [SIZE_W-1:0]   cmd_size,
  output logic                lst_rd_en,
  output logic [ADDR_W-1:0]   lst_ptr,
  input  logic [ADDR_W-1:0]   lst_addr,
  input  logic [SIZE_W-1:0]   lst_size,
  output logic                mreq_valid,
  input  logic                mreq_ready,
  output logic                mreq_put,
  output logic [TAG_W-1:0]    mreq_tag,
  output logic [ADDR_W-1:0]   mreq_addr,
  output logic [SIZE_W-1:0]   mreq_size,
  output logic [SLOT_W-1:0]   mreq_id,
  input  logic                mcpl_valid,
  input  logic [SLOT_W-1:0]   mcpl_id,
  output logic [2**TAG_W-1:0] tag_idle,
  output logic                list_err
);
  localparam int NTAG = 2 ** TAG_W;

  // per-slot control state (reset) and payload (loaded on allocation)
  logic [SLOTS-1:0]  s_valid, s_valid_n, s_done, s_done_n;
  logic [SIZE_W-1:0] s_idx [SLOTS];
  logic [SIZE_W-1:0] s_idx_n [SLOTS];
  logic [SIZE_W-1:0] s_pend [SLOTS];
  logic [SIZE_W-1:0] s_pend_n [SLOTS];
  logic [SLOTS-1:0]  s_put, s_list, s_fence, s_bar;
  logic [TAG_W-1:0]  s_tag [SLOTS];
  logic [ADDR_W-1:0] s_addr [SLOTS];
  logic [SIZE_W-1:0] s_cnt [SLOTS];

  logic [SLOTS-1:0][SLOTS-1:0] older, same_tag;
  logic [SLOTS-1:0]  blocked, eligible, sel_oh, alloc_raw, alloc_oh, free_oh;
  logic [SLOTS-1:0]  iss_v, cpl_v, abort_v, last_v;
  logic [SLOT_W-1:0] sel_idx, alloc_idx;
  logic              sel_any, alloc_any, cmd_fire, elem_zero, req_fire;

  // slot allocation: lowest free index
  dcq_first_set #(.N(SLOTS), .W(SLOT_W)) u_alloc_pick (
    .req(~s_valid), .onehot(alloc_raw), .idx(alloc_idx), .any(alloc_any)
  );

  assign cmd_ready = alloc_any;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign alloc_oh  = alloc_raw & {SLOTS{cmd_fire}};

  // relative age of occupied slots
  dcq_age_matrix #(.N(SLOTS)) u_age (
    .clk(clk), .rst_n(rst_n), .occupied(s_valid),
    .alloc_oh(alloc_oh), .free_oh(free_oh), .older(older)
  );

  // fence / barrier hold conditions
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = 0; j < SLOTS; j++)
        same_tag[i][j] = s_valid[j] && (s_tag[j] == s_tag[i]);
      blocked[i]  = (s_bar[i] && (|older[i])) ||
                    (s_fence[i] && (|(older[i] & same_tag[i])));
      eligible[i] = s_valid[i] && !s_done[i] && !blocked[i];
    end
  end

  // issue selection: lowest eligible index
  dcq_first_set #(.N(SLOTS), .W(SLOT_W)) u_issue_pick (
    .req(eligible), .onehot(sel_oh), .idx(sel_idx), .any(sel_any)
  );

  assign lst_rd_en  = sel_any && s_list[sel_idx];
  assign lst_ptr    = s_addr[sel_idx] + ADDR_W'(s_idx[sel_idx]);
  assign elem_zero  = lst_rd_en && (lst_size == '0);
  assign list_err   = elem_zero;
  assign mreq_valid = sel_any && !elem_zero;
  assign mreq_put   = s_put[sel_idx];
  assign mreq_tag   = s_tag[sel_idx];
  assign mreq_addr  = s_list[sel_idx] ? lst_addr : s_addr[sel_idx];
  assign mreq_size  = s_list[sel_idx] ? lst_size : s_cnt[sel_idx];
  assign mreq_id    = sel_idx;
  assign req_fire   = mreq_valid && mreq_ready;

  // slot next state
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      iss_v[i]   = req_fire && sel_oh[i];
      abort_v[i] = elem_zero && sel_oh[i];
      cpl_v[i]   = mcpl_valid && (mcpl_id == SLOT_W'(i));
      last_v[i]  = !s_list[i] || (SIZE_W'(s_idx[i] + SIZE_W'(1)) == s_cnt[i]);
      s_pend_n[i] = s_pend[i] + SIZE_W'(iss_v[i]) - SIZE_W'(cpl_v[i]);
      s_idx_n[i]  = s_idx[i] + SIZE_W'(iss_v[i]);
      s_done_n[i] = s_done[i] | abort_v[i] | (iss_v[i] & last_v[i]);
      free_oh[i]  = s_valid[i] && s_done_n[i] && (s_pend_n[i] == '0);
      s_valid_n[i] = s_valid[i] && !free_oh[i];
      if (alloc_oh[i]) begin
        s_valid_n[i] = 1'b1;
        s_done_n[i]  = cmd_list && (cmd_size == '0);
        s_pend_n[i]  = '0;
        s_idx_n[i]   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= '0;
      s_done  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        s_idx[i]  <= '0;
        s_pend[i] <= '0;
      end
    end else begin
      s_valid <= s_valid_n;
      s_done  <= s_done_n;
      for (int i = 0; i < SLOTS; i++) begin
        s_idx[i]  <= s_idx_n[i];
        s_pend[i] <= s_pend_n[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (alloc_oh[i]) begin
        s_put[i]   <= cmd_put;
        s_list[i]  <= cmd_list;
        s_fence[i] <= cmd_fence;
        s_bar[i]   <= cmd_barrier;
        s_tag[i]   <= cmd_tag;
        s_addr[i]  <= cmd_addr;
        s_cnt[i]   <= cmd_size;
      end
    end
  end

  // per-tag idle mask
  always_comb begin
    for (int t = 0; t < NTAG; t++) begin
      tag_idle[t] = 1'b1;
      for (int i = 0; i < SLOTS; i++)
        if (s_valid[i] && (s_tag[i] == TAG_W'(t))) tag_idle[t] = 1'b0;
    end
  end
endmodule

// File: rtl/dcq_checker.sv
module dcq_checker #(
  parameter int SLOTS  = 16,
  parameter int TAG_W  = 5,
  parameter int ADDR_W = 32,
  parameter int SLOT_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [TAG_W-1:0]    cmd_tag,
  input logic                mreq_valid,
  input logic                mreq_ready,
  input logic [TAG_W-1:0]    mreq_tag,
  input logic [SLOT_W-1:0]   mreq_id,
  input logic                lst_rd_en,
  input logic [ADDR_W-1:0]   lst_ptr,
  input logic [2**TAG_W-1:0] tag_idle,
  input logic                list_err,
  input logic [SLOTS-1:0]    alloc_oh,
  input logic [SLOTS-1:0]    free_oh
);
  logic [SLOT_W:0]   occ;
  logic [SLOTS-1:0]  seen;
  logic [ADDR_W-1:0] last_ptr [SLOTS];
  logic              lfire;

  assign lfire = mreq_valid && mreq_ready && lst_rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ  <= '0;
      seen <= '0;
    end else begin
      occ <= occ + (SLOT_W+1)'($countones(alloc_oh)) - (SLOT_W+1)'($countones(free_oh));
      for (int i = 0; i < SLOTS; i++) begin
        if (alloc_oh[i]) seen[i] <= 1'b0;
        else if (lfire && (mreq_id == SLOT_W'(i))) seen[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++)
      if (lfire && (mreq_id == SLOT_W'(i))) last_ptr[i] <= lst_ptr;
  end

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == (occ < (SLOT_W+1)'(SLOTS))); // R1

  AST_LIST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (lfire && seen[mreq_id]) |-> (lst_ptr == last_ptr[mreq_id] + ADDR_W'(1))); // R3

  AST_ZERO_ELEM_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    list_err |-> !mreq_valid); // R4

  AST_TAG_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !tag_idle[$past(cmd_tag)]); // R9

  AST_REQ_TAG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> !tag_idle[mreq_tag]); // R9
endmodule

bind dma_cmd_queue dcq_checker #(
  .SLOTS(SLOTS), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
) u_dcq_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_tag(cmd_tag), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
  .mreq_tag(mreq_tag), .mreq_id(mreq_id), .lst_rd_en(lst_rd_en),
  .lst_ptr(lst_ptr), .tag_idle(tag_idle), .list_err(list_err),
  .alloc_oh(alloc_oh), .free_oh(free_oh)
);

// File: tb/dma_cmd_queue_bench.sv
`timescale 1ns/1ps
module dma_cmd_queue_bench;
  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, cmd_put, cmd_list, cmd_fence, cmd_barrier;
  logic [4:0]  cmd_tag;
  logic [31:0] cmd_addr;
  logic [11:0] cmd_size;
  logic        lst_rd_en;
  logic [31:0] lst_ptr, lst_addr;
  logic [11:0] lst_size;
  logic        mreq_valid, mreq_ready, mreq_put;
  logic [4:0]  mreq_tag;
  logic [31:0] mreq_addr;
  logic [11:0] mreq_size;
  logic [3:0]  mreq_id;
  logic        mcpl_valid;
  logic [3:0]  mcpl_id;
  logic [31:0] tag_idle;
  logic        list_err;

  dma_cmd_queue u_dma_cmd_queue (.*);

  typedef struct packed {
    logic        put;
    logic [4:0]  tag;
    logic [31:0] addr;
    logic [11:0] size;
  } req_t;

  req_t  exp_q [$];
  string exp_r [$];
  int    cq [$];
  req_t  e;
  string er;
  int    total = 0, bad = 0, req_cnt = 0, err_cnt = 0, cyc = 0;
  bit    cpl_hold = 0;
  int    cpl_credit = 0;
  logic [31:0] lm_addr [64];
  logic [11:0] lm_size [64];

  assign lst_addr = lm_addr[lst_ptr[5:0]];
  assign lst_size = lm_size[lst_ptr[5:0]];

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic put, input logic [4:0] tag,
                          input logic [31:0] addr, input logic [11:0] size, input string req);
    exp_q.push_back({put, tag, addr, size});
    exp_r.push_back(req);
  endtask

  task automatic send(input logic put, input logic [4:0] tag, input logic fence,
                      input logic bar, input logic lst, input logic [31:0] addr,
                      input logic [11:0] size);
    cmd_valid = 1; cmd_put = put; cmd_tag = tag; cmd_fence = fence;
    cmd_barrier = bar; cmd_list = lst; cmd_addr = addr; cmd_size = size;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || tag_idle != '1) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0 && tag_idle == '1, req, "drain idle", tag_idle, 32'hffffffff);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // completion model then scoreboard monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if ((!cpl_hold || cpl_credit > 0) && cq.size() > 0) begin
        mcpl_valid = 1;
        mcpl_id = 4'(cq.pop_front());
        if (cpl_hold) cpl_credit--;
      end else begin
        mcpl_valid = 0;
      end
      if (list_err) err_cnt++;
      if (mreq_valid && mreq_ready) begin
        req_cnt++;
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected request addr", mreq_addr, 0);
        end else begin
          e  = exp_q.pop_front();
          er = exp_r.pop_front();
          chk(mreq_put == e.put && mreq_tag == e.tag && mreq_addr == e.addr &&
              mreq_size == e.size, er, "request fields",
              {mreq_put, mreq_tag, mreq_addr, mreq_size},
              {e.put, e.tag, e.addr, e.size});
        end
        cq.push_back(int'(mreq_id));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL all watchdog: actual=%0d expected=%0d", cyc, 0);
      finish_up();
    end
  end

  initial begin
    int b;
    rst_n = 0; cmd_valid = 0; cmd_put = 0; cmd_list = 0; cmd_fence = 0;
    cmd_barrier = 0; cmd_tag = 0; cmd_addr = 0; cmd_size = 0;
    mreq_ready = 1; mcpl_valid = 0; mcpl_id = 0;
    for (int i = 0; i < 64; i++) begin
      lm_addr[i] = 32'hd000_0000 + 32'(i * 16);
      lm_size[i] = 12'd16;
    end
    lm_addr[8]  = 32'h2000; lm_size[8]  = 12'd64;
    lm_addr[9]  = 32'h2400; lm_size[9]  = 12'd128;
    lm_addr[10] = 32'h2800; lm_size[10] = 12'd32;
    lm_addr[20] = 32'h5000; lm_size[20] = 12'd128;
    lm_addr[21] = 32'h5100; lm_size[21] = 12'd0;
    lm_addr[22] = 32'h5200; lm_size[22] = 12'd128;
    lm_addr[30] = 32'h6000; lm_size[30] = 12'd256;
    lm_addr[31] = 32'h6100; lm_size[31] = 12'd256;
    wait_n(4);
    rst_n = 1;
    wait_n(1);

    // reset state
    chk(cmd_ready == 1, "R1", "ready after reset", cmd_ready, 1);
    chk(tag_idle == '1, "R9", "idle mask after reset", tag_idle, 32'hffffffff);
    chk(mreq_valid == 0, "R2", "no request after reset", mreq_valid, 0);

    // R2: single GET and PUT
    push_exp(0, 5'd2, 32'h3000, 12'd256, "R2");
    push_exp(1, 5'd2, 32'h3100, 12'd128, "R2");
    send(0, 5'd2, 0, 0, 0, 32'h3000, 12'd256);
    send(1, 5'd2, 0, 0, 0, 32'h3100, 12'd128);
    drain("R9");

    // R3: three-element scatter list in order
    push_exp(1, 5'd6, 32'h2000, 12'd64, "R3");
    push_exp(1, 5'd6, 32'h2400, 12'd128, "R3");
    push_exp(1, 5'd6, 32'h2800, 12'd32, "R3");
    send(1, 5'd6, 0, 0, 1, 32'd8, 12'd3);
    drain("R3");

    // R4: zero-size middle element aborts the list
    b = err_cnt;
    push_exp(0, 5'd8, 32'h5000, 12'd128, "R4");
    send(0, 5'd8, 0, 0, 1, 32'd20, 12'd3);
    drain("R4");
    chk(err_cnt - b == 1, "R4", "list_err pulses", err_cnt - b, 1);

    // R1: fill all slots while memory stalls, refuse a seventeenth
    mreq_ready = 0;
    for (int k = 0; k < 16; k++) begin
      push_exp(0, 5'(k), 32'h1000 + 32'(k * 128), 12'd128, "R1");
      send(0, 5'(k), 0, 0, 0, 32'h1000 + 32'(k * 128), 12'd128);
    end
    chk(cmd_ready == 0, "R1", "ready low when full", cmd_ready, 0);
    cmd_valid = 1; cmd_put = 0; cmd_tag = 5'd16; cmd_list = 0; cmd_fence = 0;
    cmd_barrier = 0; cmd_addr = 32'h9999_0000; cmd_size = 12'd128;
    wait_n(4);
    chk(tag_idle[16] == 1, "R1", "refused command not held", tag_idle[16], 1);
    cmd_valid = 0;
    mreq_ready = 1;
    drain("R1");

    // R5 / R7: fence waits for same tag only
    cpl_hold = 1;
    b = req_cnt;
    push_exp(0, 5'd3, 32'h7000, 12'd128, "R5");
    push_exp(0, 5'd4, 32'h7200, 12'd128, "R7");
    push_exp(0, 5'd3, 32'h7100, 12'd128, "R5");
    send(0, 5'd3, 0, 0, 0, 32'h7000, 12'd128);
    send(0, 5'd3, 1, 0, 0, 32'h7100, 12'd128);
    send(0, 5'd4, 1, 0, 0, 32'h7200, 12'd128);
    wait_n(8);
    chk(req_cnt - b == 2, "R5", "fenced command held", req_cnt - b, 2);
    cpl_hold = 0;
    drain("R5");

    // R6 / R7: barrier waits for every earlier command
    cpl_hold = 1;
    b = req_cnt;
    push_exp(1, 5'd1, 32'h8000, 12'd64, "R6");
    push_exp(0, 5'd5, 32'h8200, 12'd64, "R7");
    push_exp(0, 5'd2, 32'h8100, 12'd64, "R6");
    send(1, 5'd1, 0, 0, 0, 32'h8000, 12'd64);
    send(0, 5'd2, 0, 1, 0, 32'h8100, 12'd64);
    send(0, 5'd5, 0, 0, 0, 32'h8200, 12'd64);
    wait_n(8);
    chk(req_cnt - b == 2, "R6", "barrier command held", req_cnt - b, 2);
    cpl_hold = 0;
    drain("R6");

    // R8: list slot stays busy until its last element completes
    cpl_hold = 1; cpl_credit = 0;
    b = req_cnt;
    push_exp(0, 5'd7, 32'h6000, 12'd256, "R8");
    push_exp(0, 5'd7, 32'h6100, 12'd256, "R8");
    send(0, 5'd7, 0, 0, 1, 32'd30, 12'd2);
    wait_n(6);
    chk(req_cnt - b == 2, "R8", "both elements issued", req_cnt - b, 2);
    chk(tag_idle[7] == 0, "R8", "busy with none completed", tag_idle[7], 0);
    cpl_credit = 1;
    wait_n(4);
    chk(tag_idle[7] == 0, "R8", "busy after first completion", tag_idle[7], 0);
    cpl_credit = 1;
    wait_n(4);
    chk(tag_idle[7] == 1, "R8", "idle after last completion", tag_idle[7], 1);
    cpl_hold = 0;
    drain("R8");

    // R10: empty list retires without a request
    b = req_cnt;
    send(0, 5'd9, 0, 0, 1, 32'd40, 12'd0);
    chk(tag_idle[9] == 0, "R9", "tag busy after accept", tag_idle[9], 0);
    wait_n(3);
    chk(tag_idle[9] == 1, "R10", "empty list retired", tag_idle[9], 1);
    chk(req_cnt == b, "R10", "empty list made no request", req_cnt - b, 0);

    wait_n(4);
    finish_up();
  end
endmodule